// File: doc/BRIEF.md
# Integer divider with condition flags

This block is a multi-cycle integer division unit for a processor execution stage. A request carries one or two dividend register values, a divisor, a mode, a signedness bit, two destination register indices and the current N flag. The unit captures all of these when the request is accepted. It then produces a quotient, a remainder and the N, Z, V and C flags. It also drives write enables that tell the register file which destinations to update, and a divide-by-zero trap.

Three operand shapes are supported. Word mode divides a 32-bit dividend by a 16-bit divisor and returns the remainder and quotient packed into one 32-bit value. Long mode divides by a 32-bit divisor, using either a 32-bit dividend or a 64-bit dividend built from two registers. Each shape can run unsigned or signed. Internally the unit always runs a fixed 64-step restoring division on magnitudes and corrects the signs at the end.

Top module: `divFlagUnit`

## Requirements
- R1: A zero divisor (the low 16 bits of `divisor` in word mode, all 32 bits in long mode) completes with `done` on the cycle after acceptance and `divZeroTrap` high. `quotWr`, `remWr` and `flagWr` all stay low.
- R2: In word mode (`mode`=00), `quotData` holds the 16-bit remainder in bits 31:16 and the 16-bit quotient in bits 15:0, and is written to `quotIdx`. `remWr` stays low.
- R3: Word mode overflows when the unsigned quotient is above 0xFFFF. Signed, it overflows when the quotient is outside -32768..32767; for example, -32768 / -1 overflows and -32768 / 1 does not.
- R4: On overflow, `flagWr` is high, V=1, C=0, Z=0, N equals the `prevN` value captured at acceptance, and both `quotWr` and `remWr` stay low.
- R5: Without overflow, V=0 and C=0. Z and N are taken from the quotient: its low 16 bits in word mode, its 32 bits in long mode. The flags are presented on `flagN`, `flagZ`, `flagV` and `flagC` while `flagWr` is high.
- R6: In 64-bit long mode (`mode`=1x), the dividend is `dvdHi` concatenated above `dvdLo`. The operation overflows when the quotient exceeds 0xFFFFFFFF (unsigned) or lies outside the signed 32-bit range (signed).
- R7: In long mode without overflow, the quotient is written to `quotIdx` and the remainder to `remIdx`. When the two indices are equal, only the quotient is written (`remWr` low).
- R8: 32-bit long mode (`mode`=01) never reports overflow. The quotient is truncated to 32 bits, so signed 0x80000000 / -1 gives 0x80000000 with N=1.
- R9: Signed division truncates toward zero, and the remainder takes the sign of the dividend (7 / -2 gives -3 rem 1; -7 / 2 gives -3 rem -1).
- R10: `done` is a one-cycle pulse. With a nonzero divisor it appears 65 rising edges after the edge that accepts `start`, counting that edge. `start` is ignored while `busy` is high. Inputs may change freely after acceptance.
- R11: After reset, `busy`, `done`, `divZeroTrap`, `quotWr`, `remWr` and `flagWr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted when `busy` is low |
| mode | input | 2 | 00 word, 01 long 32-bit dividend, 1x long 64-bit dividend |
| signedOp | input | 1 | 1 for signed division |
| dvdLo | input | 32 | Dividend, or its lower half in 64-bit mode |
| dvdHi | input | 32 | Upper dividend half (64-bit mode only) |
| divisor | input | 32 | Divisor; low 16 bits used in word mode |
| quotIdxIn | input | 3 | Quotient destination register index |
| remIdxIn | input | 3 | Remainder destination register index |
| prevN | input | 1 | Current N flag, kept on overflow |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result cycle pulse |
| divZeroTrap | output | 1 | Divide-by-zero trap, valid with `done` |
| quotWr | output | 1 | Write `quotData` to `quotIdx` |
| remWr | output | 1 | Write `remData` to `remIdx` |
| flagWr | output | 1 | Update flags |
| quotIdx | output | 3 | Captured quotient index |
| remIdx | output | 3 | Captured remainder index |
| quotData | output | 32 | Quotient (long) or packed remainder:quotient (word) |
| remData | output | 32 | Signed-corrected remainder |
| flagN | output | 1 | N flag |
| flagZ | output | 1 | Z flag |
| flagV | output | 1 | V flag |
| flagC | output | 1 | C flag |

## Verification
Two things can coincide: a fresh `start` arriving in the same cycle the unit presents `done`, and overflow detection together with destination selection when both destination indices are equal. The bench holds `start` high through an entire operation, including its completion cycle, with a zero divisor on the inputs. It then checks that exactly one completion appears, at the nominal latency, carrying the first operation's result. A 64-bit overflow case is run with equal destination indices, and the bench checks that neither write enable rises while the flags still follow the overflow policy.

// File: rtl/divPkg.sv
package divPkg;
  // mode encodings on the request port
  localparam logic [1:0] MODE_WORD   = 2'b00;
  localparam logic [1:0] MODE_LONG32 = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } divStateT;

  typedef struct packed {
    logic load;   // capture request and operands
    logic step;   // one restoring iteration
    logic done;   // results presented this cycle
  } ctrlStrobeT;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int ITER = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divisorZero,
  output ctrlStrobeT strb,
  output logic       busy
);
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;

  divStateT         state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= divisorZero ? ST_FIN : ST_RUN;
          stepCnt <= CNT_W'(ITER - 1);
        end
        ST_RUN: begin
          if (stepCnt == '0) state <= ST_FIN;
          else stepCnt <= stepCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load = (state == ST_IDLE) && start;
    strb.step = (state == ST_RUN);
    strb.done = (state == ST_FIN);
    busy      = (state != ST_IDLE);
  end
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [1:0]        mode,
  input  logic              signedOp,
  input  logic [DATA_W-1:0] dvdLo,
  input  logic [DATA_W-1:0] dvdHi,
  input  logic [DATA_W-1:0] divisor,
  input  logic [IDX_W-1:0]  quotIdxIn,
  input  logic [IDX_W-1:0]  remIdxIn,
  input  logic              prevN,
  output logic              divisorZero,
  output logic              divZeroTrap,
  output logic              quotWr,
  output logic              remWr,
  output logic              flagWr,
  output logic [IDX_W-1:0]  quotIdx,
  output logic [IDX_W-1:0]  remIdx,
  output logic [DATA_W-1:0] quotData,
  output logic [DATA_W-1:0] remData,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);
  localparam int DVD_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DVD_W-1:0] ONE       = 1;
  localparam logic [DVD_W-1:0] HALF_UMAX = (ONE << HALF_W) - ONE;
  localparam logic [DVD_W-1:0] HALF_SMAX = (ONE << (HALF_W - 1)) - ONE;
  localparam logic [DVD_W-1:0] FULL_UMAX = (ONE << DATA_W) - ONE;
  localparam logic [DVD_W-1:0] FULL_SMAX = (ONE << (DATA_W - 1)) - ONE;

  // operand preparation (request side)
  logic              isWordIn, isL64In, dvdNeg, dvsNeg;
  logic [DATA_W-1:0] dvsFull, dvsMag;
  logic [DVD_W-1:0]  dvdFull, dvdMag;

  always_comb begin
    isWordIn = (mode == MODE_WORD);
    isL64In  = mode[1];
    if (isWordIn)
      dvsFull = signedOp ? {{HALF_W{divisor[HALF_W-1]}}, divisor[HALF_W-1:0]}
                         : {{HALF_W{1'b0}}, divisor[HALF_W-1:0]};
    else
      dvsFull = divisor;
    if (isL64In)
      dvdFull = {dvdHi, dvdLo};
    else
      dvdFull = signedOp ? {{DATA_W{dvdLo[DATA_W-1]}}, dvdLo} : {{DATA_W{1'b0}}, dvdLo};
    divisorZero = (dvsFull == '0);
    dvdNeg = signedOp & dvdFull[DVD_W-1];
    dvsNeg = signedOp & dvsFull[DATA_W-1];
    dvdMag = dvdNeg ? -dvdFull : dvdFull;
    dvsMag = dvsNeg ? -dvsFull : dvsFull;
  end

  // captured request and iteration state
  logic [DVD_W-1:0]  accQ;
  logic [DATA_W-1:0] partRem, dvsR;
  logic              negQ, negR, trapR, wordR, long32R, signedR, prevNR;

  logic [DATA_W:0]   shifted;
  logic              canSub;

  always_comb begin
    shifted = {partRem, accQ[DVD_W-1]};
    canSub  = (shifted >= {1'b0, dvsR});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      partRem <= '0;
      dvsR    <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
      trapR   <= 1'b0;
      wordR   <= 1'b0;
      long32R <= 1'b0;
      signedR <= 1'b0;
      prevNR  <= 1'b0;
      quotIdx <= '0;
      remIdx  <= '0;
    end else if (strb.load) begin
      accQ    <= dvdMag;
      partRem <= '0;
      dvsR    <= dvsMag;
      negQ    <= dvdNeg ^ dvsNeg;
      negR    <= dvdNeg;
      trapR   <= divisorZero;
      wordR   <= isWordIn;
      long32R <= (mode == MODE_LONG32);
      signedR <= signedOp;
      prevNR  <= prevN;
      quotIdx <= quotIdxIn;
      remIdx  <= remIdxIn;
    end else if (strb.step) begin
      partRem <= canSub ? DATA_W'(shifted - {1'b0, dvsR}) : shifted[DATA_W-1:0];
      accQ    <= {accQ[DVD_W-2:0], canSub};
    end
  end

  // result correction, overflow and flags
  logic [DATA_W-1:0] qSigned, rSigned;
  logic [DVD_W-1:0]  qLimit;
  logic              ovf, qZero, qNeg;

  always_comb begin
    qSigned = negQ ? -accQ[DATA_W-1:0] : accQ[DATA_W-1:0];
    rSigned = negR ? -partRem : partRem;
    if (wordR)
      qLimit = !signedR ? HALF_UMAX : (negQ ? HALF_SMAX + ONE : HALF_SMAX);
    else
      qLimit = !signedR ? FULL_UMAX : (negQ ? FULL_SMAX + ONE : FULL_SMAX);
    ovf   = !long32R && (accQ > qLimit);
    qZero = wordR ? (qSigned[HALF_W-1:0] == '0) : (qSigned == '0);
    qNeg  = wordR ? qSigned[HALF_W-1] : qSigned[DATA_W-1];

    quotData = wordR ? {rSigned[HALF_W-1:0], qSigned[HALF_W-1:0]} : qSigned;
    remData  = rSigned;
    flagN    = ovf ? prevNR : qNeg;
    flagZ    = !ovf && qZero;
    flagV    = ovf;
    flagC    = 1'b0;

    divZeroTrap = strb.done && trapR;
    flagWr      = strb.done && !trapR;
    quotWr      = flagWr && !ovf;
    remWr       = quotWr && !wordR && (remIdx != quotIdx);
  end
endmodule

// File: rtl/divFlagUnit.sv
module divFlagUnit
  import divPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              signedOp,
  input  logic [DATA_W-1:0] dvdLo,
  input  logic [DATA_W-1:0] dvdHi,
  input  logic [DATA_W-1:0] divisor,
  input  logic [IDX_W-1:0]  quotIdxIn,
  input  logic [IDX_W-1:0]  remIdxIn,
  input  logic              prevN,
  output logic              busy,
  output logic              done,
  output logic              divZeroTrap,
  output logic              quotWr,
  output logic              remWr,
  output logic              flagWr,
  output logic [IDX_W-1:0]  quotIdx,
  output logic [IDX_W-1:0]  remIdx,
  output logic [DATA_W-1:0] quotData,
  output logic [DATA_W-1:0] remData,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);
  localparam int ITER = 2 * DATA_W;

  ctrlStrobeT strb;
  logic       divisorZero;

  divCtrl #(.ITER(ITER)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .divisorZero(divisorZero),
    .strb(strb), .busy(busy)
  );

  divDatapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode), .signedOp(signedOp),
    .dvdLo(dvdLo), .dvdHi(dvdHi), .divisor(divisor),
    .quotIdxIn(quotIdxIn), .remIdxIn(remIdxIn), .prevN(prevN),
    .divisorZero(divisorZero), .divZeroTrap(divZeroTrap),
    .quotWr(quotWr), .remWr(remWr), .flagWr(flagWr),
    .quotIdx(quotIdx), .remIdx(remIdx), .quotData(quotData), .remData(remData),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  assign done = strb.done;
endmodule

// File: rtl/divFlagUnitChk.sv
module divFlagUnitChk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             prevN,
  input logic             busy,
  input logic             done,
  input logic             divZeroTrap,
  input logic             quotWr,
  input logic             remWr,
  input logic             flagWr,
  input logic [IDX_W-1:0] quotIdx,
  input logic [IDX_W-1:0] remIdx,
  input logic             flagN,
  input logic             flagZ,
  input logic             flagV,
  input logic             flagC
);
  logic nAtStart;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nAtStart <= 1'b0;
    else if (start && !busy) nAtStart <= prevN;
  end

  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    divZeroTrap |-> !(quotWr || remWr || flagWr)); // R1
  AST_OVF_POLICY: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && flagV) |-> (!flagC && !flagZ && !quotWr && !remWr)); // R4
  AST_OVF_KEEPS_N: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && flagV) |-> (flagN == nAtStart)); // R4
  AST_NO_OVERFLOW_CLEARS_C: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && !flagV) |-> !flagC); // R5
  AST_SAME_REG_QUOT: assert property (@(posedge clk) disable iff (!rstN)
    remWr |-> (remIdx != quotIdx)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R10
  AST_QUIET_OUTSIDE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !(quotWr || remWr || flagWr || divZeroTrap)); // R10
endmodule

bind divFlagUnit divFlagUnitChk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .prevN(prevN), .busy(busy),
  .done(done), .divZeroTrap(divZeroTrap), .quotWr(quotWr), .remWr(remWr),
  .flagWr(flagWr), .quotIdx(quotIdx), .remIdx(remIdx),
  .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
);

// File: tb/divFlagUnit_tb.sv
`timescale 1ns/100ps
module divFlagUnit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        signedOp = 1'b0;
  logic [31:0] dvdLo = '0, dvdHi = '0, divisor = '0;
  logic [2:0]  quotIdxIn = '0, remIdxIn = '0;
  logic        prevN = 1'b0;
  logic        busy, done, divZeroTrap, quotWr, remWr, flagWr;
  logic [2:0]  quotIdx, remIdx;
  logic [31:0] quotData, remData;
  logic        flagN, flagZ, flagV, flagC;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  divFlagUnit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .signedOp(signedOp),
    .dvdLo(dvdLo), .dvdHi(dvdHi), .divisor(divisor),
    .quotIdxIn(quotIdxIn), .remIdxIn(remIdxIn), .prevN(prevN),
    .busy(busy), .done(done), .divZeroTrap(divZeroTrap),
    .quotWr(quotWr), .remWr(remWr), .flagWr(flagWr),
    .quotIdx(quotIdx), .remIdx(remIdx), .quotData(quotData), .remData(remData),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        sgn;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [31:0] dvs;
    logic [2:0]  qi;
    logic [2:0]  ri;
    logic        pn;
    logic        eTrap;
    logic        eQWr;
    logic        eRWr;
    logic [31:0] eQ;
    logic [31:0] eR;
    logic [3:0]  eF;   // {N,Z,V,C}
  } vecT;

  localparam int NV = 21;
  localparam vecT VECS [NV] = '{
    '{2'd0,1'b0,32'h0,32'h00000064,32'h00000007,3'd1,3'd2,1'b0, 1'b0,1'b1,1'b0,32'h0002000E,32'h0,4'b0000}, // R2 R5
    '{2'd0,1'b1,32'h0,32'hFFFFFF9C,32'h00000007,3'd1,3'd2,1'b0, 1'b0,1'b1,1'b0,32'hFFFEFFF2,32'h0,4'b1000}, // R2 R9
    '{2'd0,1'b0,32'h0,32'h00100000,32'hABCD0001,3'd1,3'd2,1'b1, 1'b0,1'b0,1'b0,32'h0,32'h0,4'b1010},       // R3 R4
    '{2'd0,1'b1,32'h0,32'h00008000,32'h00000001,3'd1,3'd2,1'b0, 1'b0,1'b0,1'b0,32'h0,32'h0,4'b0010},       // R3
    '{2'd0,1'b1,32'h0,32'hFFFF8000,32'h00000001,3'd1,3'd2,1'b0, 1'b0,1'b1,1'b0,32'h00008000,32'h0,4'b1000},// R3
    '{2'd0,1'b1,32'h0,32'hFFFF8000,32'h0000FFFF,3'd1,3'd2,1'b1, 1'b0,1'b0,1'b0,32'h0,32'h0,4'b1010},       // R3
    '{2'd0,1'b0,32'h0,32'h00000005,32'h00000007,3'd1,3'd2,1'b0, 1'b0,1'b1,1'b0,32'h00050000,32'h0,4'b0100},// R5
    '{2'd0,1'b0,32'h0,32'h00000005,32'h12340000,3'd1,3'd2,1'b0, 1'b1,1'b0,1'b0,32'h0,32'h0,4'b0000},       // R1
    '{2'd1,1'b0,32'h0,32'hFFFFFFFF,32'h00000010,3'd1,3'd2,1'b0, 1'b0,1'b1,1'b1,32'h0FFFFFFF,32'hF,4'b0000},// R7
    '{2'd1,1'b1,32'h0,32'h80000000,32'hFFFFFFFF,3'd4,3'd5,1'b0, 1'b0,1'b1,1'b1,32'h80000000,32'h0,4'b1000},// R8
    '{2'd1,1'b1,32'h0,32'h00000007,32'hFFFFFFFE,3'd4,3'd5,1'b0, 1'b0,1'b1,1'b1,32'hFFFFFFFD,32'h1,4'b1000},// R9
    '{2'd1,1'b1,32'h0,32'hFFFFFFF9,32'h00000002,3'd4,3'd5,1'b0, 1'b0,1'b1,1'b1,32'hFFFFFFFD,32'hFFFFFFFF,4'b1000}, // R9
    '{2'd2,1'b0,32'h1,32'h00000000,32'h00000002,3'd0,3'd7,1'b0, 1'b0,1'b1,1'b1,32'h80000000,32'h0,4'b1000},// R6
    '{2'd2,1'b0,32'h1,32'h00000000,32'h00000001,3'd6,3'd6,1'b1, 1'b0,1'b0,1'b0,32'h0,32'h0,4'b1010},       // R6 R4 R7
    '{2'd2,1'b1,32'h0,32'h80000000,32'h00000001,3'd0,3'd7,1'b0, 1'b0,1'b0,1'b0,32'h0,32'h0,4'b0010},       // R6
    '{2'd2,1'b1,32'hFFFFFFFF,32'h80000000,32'h00000001,3'd0,3'd7,1'b0, 1'b0,1'b1,1'b1,32'h80000000,32'h0,4'b1000}, // R6
    '{2'd2,1'b0,32'h0,32'h00000064,32'h00000007,3'd3,3'd3,1'b0, 1'b0,1'b1,1'b0,32'h0000000E,32'h0,4'b0000},// R7
    '{2'd2,1'b0,32'h5,32'h00000005,32'h00000000,3'd3,3'd4,1'b0, 1'b1,1'b0,1'b0,32'h0,32'h0,4'b0000},       // R1
    '{2'd3,1'b1,32'hFFFFFFFF,32'hFFFFFF9C,32'h00000007,3'd1,3'd2,1'b0, 1'b0,1'b1,1'b1,32'hFFFFFFF2,32'hFFFFFFFE,4'b1000}, // R9
    '{2'd1,1'b0,32'h0,32'h00000000,32'h00000005,3'd1,3'd2,1'b1, 1'b0,1'b1,1'b1,32'h0,32'h0,4'b0100},       // R5 R8
    '{2'd2,1'b0,32'hF,32'hFFFFFFFF,32'h00000010,3'd1,3'd2,1'b0, 1'b0,1'b1,1'b1,32'hFFFFFFFF,32'hF,4'b1000} // R6
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one request, scramble inputs after acceptance, return latency
  task automatic runOp(input vecT v, output int lat);
    @(negedge clk);
    mode = v.mode; signedOp = v.sgn; dvdHi = v.hi; dvdLo = v.lo; divisor = v.dvs;
    quotIdxIn = v.qi; remIdxIn = v.ri; prevN = v.pn; start = 1'b1;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        start = 1'b0;
        dvdLo = ~v.lo; dvdHi = ~v.hi; divisor = 32'h5A5A5A5A;
        quotIdxIn = ~v.qi; remIdxIn = ~v.ri; prevN = ~v.pn; signedOp = ~v.sgn;
      end
      if (done || lat > 300) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    int lat;
    int doneCnt;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", "busy in reset", {31'b0, busy}, 32'd0);
    chk("R11", "done in reset", {31'b0, done}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "busy after reset", {31'b0, busy}, 32'd0);
    chk("R11", "writes after reset", {28'b0, divZeroTrap, quotWr, remWr, flagWr}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i], lat);
      chk("R10", $sformatf("v%0d latency", i), lat, VECS[i].eTrap ? 32'd1 : 32'd65);
      chk("R1", $sformatf("v%0d trap", i), {31'b0, divZeroTrap}, {31'b0, VECS[i].eTrap});
      chk("R1", $sformatf("v%0d flagWr", i), {31'b0, flagWr}, {31'b0, ~VECS[i].eTrap});
      chk("R7", $sformatf("v%0d quotWr", i), {31'b0, quotWr}, {31'b0, VECS[i].eQWr});
      chk("R7", $sformatf("v%0d remWr", i), {31'b0, remWr}, {31'b0, VECS[i].eRWr});
      if (VECS[i].eQWr) begin
        chk("R2", $sformatf("v%0d quotData", i), quotData, VECS[i].eQ);
        chk("R7", $sformatf("v%0d quotIdx", i), {29'b0, quotIdx}, {29'b0, VECS[i].qi});
      end
      if (VECS[i].eRWr) begin
        chk("R9", $sformatf("v%0d remData", i), remData, VECS[i].eR);
        chk("R7", $sformatf("v%0d remIdx", i), {29'b0, remIdx}, {29'b0, VECS[i].ri});
      end
      if (!VECS[i].eTrap)
        chk(VECS[i].eF[1] ? "R4" : "R5", $sformatf("v%0d NZVC", i),
            {28'b0, flagN, flagZ, flagV, flagC}, {28'b0, VECS[i].eF});
      @(negedge clk);
      chk("R10", $sformatf("v%0d done pulse", i), {30'b0, done, busy}, 32'd0);
    end

    // R10: start held through busy and completion with a zero divisor on inputs
    @(negedge clk);
    mode = 2'b01; signedOp = 1'b0; dvdLo = 32'd1000; divisor = 32'd3;
    quotIdxIn = 3'd1; remIdxIn = 3'd2; prevN = 1'b0; start = 1'b1;
    lat = 0; doneCnt = 0;
    @(negedge clk);
    lat = 1;
    divisor = 32'd0; dvdLo = 32'd5;
    for (int k = 0; k < 80; k++) begin
      if (done) begin
        doneCnt++;
        chk("R10", "held-start latency", lat, 32'd65);
        chk("R10", "held-start quotient", quotData, 32'd333);
        chk("R10", "held-start remainder", remData, 32'd1);
        chk("R10", "held-start no trap", {31'b0, divZeroTrap}, 32'd0);
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    chk("R10", "held-start single completion", doneCnt, 32'd1);
    chk("R10", "idle after completion", {31'b0, busy}, 32'd0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule